// File: doc/BRIEF.md
# Debug Register Scan Access Unit

This unit sits behind a test access port and lets an external host reach a small bank of 32-bit debug registers through one serial chain. The test access port controller supplies capture, shift and update strobes plus serial input and output. A chain-select input qualifies all three strobes. Each scan carries a data word, a register address and a write flag. A write takes effect at update. A read is pipelined: the address sent in one scan is fetched at that scan's update, and the value comes out during the next scan.

On the target side the unit drives the debug control, vector catch and watch-unit registers to the debug logic. It samples a status word from that logic. It also holds a two-way mailbox. The host writes words down to the target. The target pushes words up, and a host read of the mailbox data address consumes the waiting word.

Top module: `dbgscan_unit`

## Requirements
- R1: The chain is 38 bits long and shifts toward tdo. Chain bit 0 is the first bit out and the first bit in. Bits 31:0 are data, bits 36:32 are the register address and bit 37 is the write flag. A capture loads the read word into bits 31:0 and zeros into bits 37:32.
- R2: An update with write flag 1 stores the data into the addressed register. A stored register changes only through such an update, or through reset.
- R3: An update with write flag 0 fetches the addressed register, and the next capture returns that value. The capture after a write scan returns zero, and so does the first capture after reset. Reading N registers takes N+1 scans.
- R4: Address map: control 0x00, status 0x01 (read-only, taken from stat_i), vector catch 0x02, mailbox control 0x04 and mailbox data 0x05. Watch unit u occupies (u+1)*8 through (u+1)*8+5. Every other address reads as zero and ignores writes.
- R5: The six slots of a watch unit, in rising address order, are address value, address mask, data value, data mask, control value and control mask. Slot s of unit u appears on watch_o bits [(u*6+s)*32 +: 32].
- R6: A read update of 0x05 clears the up-mailbox full flag unless the target pushes in the same cycle. A trailing scan that repeats 0x05 therefore consumes another word.
- R7: A read of 0x04 has no side effect on either mailbox flag.
- R8: Control is 6 bits and vector catch is 8 bits. Both read back zero-extended, and written bits above their width are dropped. Bit 4 of control (monitor-mode enable) can be set or cleared through read-modify-write without disturbing the other bits.
- R9: While chain_sel is low, capture, shift and update have no effect.
- R10: A host write to 0x05 stores dn_word_o and sets dn_full_o. dn_pop_i clears dn_full_o, and a host write in the same cycle takes priority over the pop.
- R11: up_push_i stores up_word_i and sets up_full_o, taking priority over a host consume. A later read of 0x05 returns that word.
- R12: Mailbox control reads with bit 0 = down-mailbox full, bit 1 = up-mailbox full, and bits 31:28 = the VERSION parameter (default 2). All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This chain is the active chain |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| stat_i | input | 5 | Status from debug logic |
| ctrl_o | output | 6 | Debug control register |
| vcatch_o | output | 8 | Vector catch register |
| watch_o | output | 384 | Watch unit registers, flattened |
| up_word_i | input | 32 | Word pushed by target |
| up_push_i | input | 1 | Target push strobe |
| up_full_o | output | 1 | Up mailbox holds an unread word |
| dn_word_o | output | 32 | Word written down by host |
| dn_full_o | output | 1 | Down mailbox holds a word |
| dn_pop_i | input | 1 | Target takes the down word |

## Verification
On every cycle the assertions check the following: the chain stays frozen while deselected, each shift moves the next chain bit onto tdo, and control changes only after a write update to its address. They also check that a mailbox-data read clears the up flag, that a mailbox-control read leaves both flags alone, that a host mailbox write sets the down flag, and that a control fetch holds zeros above bit 5. Only the bench scenarios can show the rest. These are the one-scan read latency, the contents of the address map including the holes, the watch slot order on watch_o, the extra consume from a repeated trailing mailbox read, and the read-modify-write of the monitor bit.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int CHAIN_W = DATA_W + ADDR_W + 1;
    localparam int WP_REGS = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h01;
    localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
    localparam logic [ADDR_W-1:0] A_COMCTL = 5'h04;
    localparam logic [ADDR_W-1:0] A_COMDAT = 5'h05;

    // Packed so that bit 0 is the first chain bit: data, then address, then write flag
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_pkt_t;

    typedef enum logic [2:0] {
        K_NONE, K_CTRL, K_STAT, K_VCATCH, K_COMCTL, K_COMDAT, K_WATCH
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] unit;
        logic [2:0] slot;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int num_wp);
        reg_sel_t s;
        s.kind = K_NONE;
        s.unit = '0;
        s.slot = '0;
        case (a)
            A_CTRL:   s.kind = K_CTRL;
            A_STAT:   s.kind = K_STAT;
            A_VCATCH: s.kind = K_VCATCH;
            A_COMCTL: s.kind = K_COMCTL;
            A_COMDAT: s.kind = K_COMDAT;
            default: begin
                if (a[4:3] != 2'b00 && int'(a[4:3]) <= num_wp && a[2:0] < 3'd6) begin
                    s.kind = K_WATCH;
                    s.unit = a[4:3] - 2'd1;
                    s.slot = a[2:0];
                end
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dbgscan_chain.sv
module dbgscan_chain
    import dbgscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              cap_en,
    input  logic              sh_en,
    input  logic              upd_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_word,
    output logic              tdo,
    output scan_pkt_t         pkt,
    output logic              upd_fire
);
    logic [CHAIN_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (sel && cap_en) begin
            sr_q <= {{(CHAIN_W-DATA_W){1'b0}}, cap_word};
        end else if (sel && sh_en) begin
            sr_q <= {tdi, sr_q[CHAIN_W-1:1]};
        end
    end

    assign tdo      = sr_q[0];
    assign pkt      = scan_pkt_t'(sr_q);
    assign upd_fire = sel & upd_en;

    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(sr_q)); // R9
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (sel && sh_en && !cap_en) |=> tdo == $past(sr_q[1])); // R1
endmodule

// File: rtl/dbgscan_regs.sv
module dbgscan_regs
    import dbgscan_pkg::*;
#(
    parameter int         NUM_WP  = 2,
    parameter int         CTRL_W  = 6,
    parameter int         STAT_W  = 5,
    parameter int         VC_W    = 8,
    parameter logic [3:0] VERSION = 4'h2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            upd_fire,
    input  scan_pkt_t                       pkt,
    input  logic [STAT_W-1:0]               stat_i,
    input  logic [DATA_W-1:0]               up_word_i,
    input  logic                            up_push_i,
    input  logic                            dn_pop_i,
    output logic [CTRL_W-1:0]               ctrl_o,
    output logic [VC_W-1:0]                 vcatch_o,
    output logic [NUM_WP*WP_REGS*DATA_W-1:0] watch_o,
    output logic                            up_full_o,
    output logic [DATA_W-1:0]               dn_word_o,
    output logic                            dn_full_o,
    output logic [DATA_W-1:0]               rd_word
);
    localparam int NUM_SLOTS = NUM_WP * WP_REGS;
    localparam int IDX_W     = $clog2(NUM_SLOTS);

    logic [CTRL_W-1:0] ctrl_q;
    logic [VC_W-1:0]   vcatch_q;
    logic [DATA_W-1:0] wp_q [NUM_SLOTS];
    logic [DATA_W-1:0] up_word_q, dn_word_q, rd_hold_q, rv;
    logic              up_full_q, dn_full_q;
    logic              wr_fire, rd_fire;
    reg_sel_t          rs;
    logic [IDX_W-1:0]  idx;

    assign wr_fire = upd_fire &  pkt.wr;
    assign rd_fire = upd_fire & ~pkt.wr;
    assign rs      = decode_addr(pkt.addr, NUM_WP);
    assign idx     = IDX_W'(int'(rs.unit) * WP_REGS + int'(rs.slot));

    always_comb begin
        rv = '0;
        case (rs.kind)
            K_CTRL:   rv[CTRL_W-1:0] = ctrl_q;
            K_STAT:   rv[STAT_W-1:0] = stat_i;
            K_VCATCH: rv[VC_W-1:0]   = vcatch_q;
            K_COMCTL: begin
                rv[0]            = dn_full_q;
                rv[1]            = up_full_q;
                rv[DATA_W-1 -: 4] = VERSION;
            end
            K_COMDAT: rv = up_word_q;
            K_WATCH:  rv = wp_q[idx];
            default:  rv = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            vcatch_q  <= '0;
            rd_hold_q <= '0;
            up_word_q <= '0;
            up_full_q <= 1'b0;
            dn_word_q <= '0;
            dn_full_q <= 1'b0;
        end else begin
            if (wr_fire && rs.kind == K_CTRL)   ctrl_q   <= pkt.data[CTRL_W-1:0];
            if (wr_fire && rs.kind == K_VCATCH) vcatch_q <= pkt.data[VC_W-1:0];
            if (upd_fire) rd_hold_q <= rd_fire ? rv : '0;

            if (wr_fire && rs.kind == K_COMDAT) begin
                dn_word_q <= pkt.data;
                dn_full_q <= 1'b1;
            end else if (dn_pop_i) begin
                dn_full_q <= 1'b0;
            end

            if (up_push_i) begin
                up_word_q <= up_word_i;
                up_full_q <= 1'b1;
            end else if (rd_fire && rs.kind == K_COMDAT) begin
                up_full_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_wp
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'((g / WP_REGS + 1) * 8 + g % WP_REGS);
        always_ff @(posedge clk) begin
            if (rst)                               wp_q[g] <= '0;
            else if (wr_fire && pkt.addr == MY_ADDR) wp_q[g] <= pkt.data;
        end
        assign watch_o[g*DATA_W +: DATA_W] = wp_q[g];
    end

    assign ctrl_o    = ctrl_q;
    assign vcatch_o  = vcatch_q;
    assign up_full_o = up_full_q;
    assign dn_word_o = dn_word_q;
    assign dn_full_o = dn_full_q;
    assign rd_word   = rd_hold_q;

    AST_CTRL_WR_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(upd_fire && pkt.wr && pkt.addr == A_CTRL)); // R2
    AST_UP_CONSUME: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && !pkt.wr && pkt.addr == A_COMDAT && !up_push_i) |=> !up_full_q); // R6
    AST_COMCTL_PURE: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && !pkt.wr && pkt.addr == A_COMCTL && !up_push_i && !dn_pop_i)
        |=> ($stable(up_full_q) && $stable(dn_full_q))); // R7
    AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && !pkt.wr && pkt.addr == A_CTRL) |=> rd_hold_q[DATA_W-1:CTRL_W] == '0); // R8
    AST_DN_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && pkt.wr && pkt.addr == A_COMDAT) |=> dn_full_q); // R10
endmodule

// File: rtl/dbgscan_unit.sv
module dbgscan_unit
    import dbgscan_pkg::*;
#(
    parameter int         NUM_WP  = 2,
    parameter int         CTRL_W  = 6,
    parameter int         STAT_W  = 5,
    parameter int         VC_W    = 8,
    parameter logic [3:0] VERSION = 4'h2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             chain_sel,
    input  logic                             capture_en,
    input  logic                             shift_en,
    input  logic                             update_en,
    input  logic                             tdi,
    output logic                             tdo,
    input  logic [STAT_W-1:0]                stat_i,
    output logic [CTRL_W-1:0]                ctrl_o,
    output logic [VC_W-1:0]                  vcatch_o,
    output logic [NUM_WP*WP_REGS*DATA_W-1:0] watch_o,
    input  logic [DATA_W-1:0]                up_word_i,
    input  logic                             up_push_i,
    output logic                             up_full_o,
    output logic [DATA_W-1:0]                dn_word_o,
    output logic                             dn_full_o,
    input  logic                             dn_pop_i
);
    scan_pkt_t         pkt;
    logic              upd_fire;
    logic [DATA_W-1:0] rd_word;

    dbgscan_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .sel      (chain_sel),
        .cap_en   (capture_en),
        .sh_en    (shift_en),
        .upd_en   (update_en),
        .tdi      (tdi),
        .cap_word (rd_word),
        .tdo      (tdo),
        .pkt      (pkt),
        .upd_fire (upd_fire)
    );

    dbgscan_regs #(
        .NUM_WP (NUM_WP),
        .CTRL_W (CTRL_W),
        .STAT_W (STAT_W),
        .VC_W   (VC_W),
        .VERSION(VERSION)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .upd_fire  (upd_fire),
        .pkt       (pkt),
        .stat_i    (stat_i),
        .up_word_i (up_word_i),
        .up_push_i (up_push_i),
        .dn_pop_i  (dn_pop_i),
        .ctrl_o    (ctrl_o),
        .vcatch_o  (vcatch_o),
        .watch_o   (watch_o),
        .up_full_o (up_full_o),
        .dn_word_o (dn_word_o),
        .dn_full_o (dn_full_o),
        .rd_word   (rd_word)
    );
endmodule

// File: tb/sim_dbgscan_unit.sv
module sim_dbgscan_unit;
    logic         clk = 1'b0;
    logic         rst, chain_sel, capture_en, shift_en, update_en, tdi;
    logic         tdo;
    logic [4:0]   stat_i;
    logic [5:0]   ctrl_o;
    logic [7:0]   vcatch_o;
    logic [383:0] watch_o;
    logic [31:0]  up_word_i, dn_word_o;
    logic         up_push_i, up_full_o, dn_full_o, dn_pop_i;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [37:0] cap;

    always #2 clk = ~clk;

    dbgscan_unit u0 (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
        .stat_i(stat_i), .ctrl_o(ctrl_o), .vcatch_o(vcatch_o), .watch_o(watch_o),
        .up_word_i(up_word_i), .up_push_i(up_push_i), .up_full_o(up_full_o),
        .dn_word_o(dn_word_o), .dn_full_o(dn_full_o), .dn_pop_i(dn_pop_i)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
        end
    endtask

    // One full scan: capture, 38 shifts, update. Returns captured chain bits.
    task automatic scan(input logic sel, input logic wr, input logic [4:0] addr,
                        input logic [31:0] data, output logic [37:0] got);
        logic [37:0] pv;
        pv = {wr, addr, data};
        chain_sel  = sel;
        capture_en = 1'b1;
        @(posedge clk); @(negedge clk);
        capture_en = 1'b0;
        shift_en   = 1'b1;
        for (int i = 0; i < 38; i++) begin
            tdi    = pv[i];
            #0.5;
            got[i] = tdo;
            @(posedge clk); @(negedge clk);
        end
        shift_en  = 1'b0;
        update_en = 1'b1;
        @(posedge clk); @(negedge clk);
        update_en = 1'b0;
        chain_sel = 1'b1;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] g;
        scan(1'b1, 1'b1, a, d, g);
    endtask

    // Read with a trailing mailbox-control scan, which has no side effect
    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        logic [37:0] g;
        scan(1'b1, 1'b0, a, 32'h0, g);
        scan(1'b1, 1'b0, 5'h04, 32'h0, g);
        d = g[31:0];
    endtask

    task automatic push_up(input logic [31:0] w);
        up_word_i = w;
        up_push_i = 1'b1;
        @(posedge clk); @(negedge clk);
        up_push_i = 1'b0;
    endtask

    // {addr, write data, expected readback}
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h0000_003F},  // R8 control width
        {5'h01, 32'hFFFF_FFFF, 32'h0000_0015},  // R4 status read-only
        {5'h02, 32'hA5A5_A5FF, 32'h0000_00FF},  // R8 vector catch width
        {5'h03, 32'hDEAD_BEEF, 32'h0000_0000},  // R4 hole
        {5'h08, 32'h1111_1111, 32'h1111_1111},  // R5
        {5'h0B, 32'h4444_4444, 32'h4444_4444},  // R5
        {5'h0D, 32'h6666_6666, 32'h6666_6666},  // R5
        {5'h10, 32'h7777_7777, 32'h7777_7777},  // R5
        {5'h15, 32'hCCCC_CCCC, 32'hCCCC_CCCC},  // R5
        {5'h0E, 32'h1234_5678, 32'h0000_0000},  // R4 hole
        {5'h16, 32'h8765_4321, 32'h0000_0000},  // R4 hole
        {5'h1F, 32'hFFFF_FFFF, 32'h0000_0000}   // R4 hole
    };

    initial begin
        logic [31:0] rd;
        rst = 1'b1; chain_sel = 1'b1; capture_en = 1'b0; shift_en = 1'b0;
        update_en = 1'b0; tdi = 1'b0; stat_i = 5'h15; up_word_i = '0;
        up_push_i = 1'b0; dn_pop_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R3 reset ctrl", {26'd0, ctrl_o}, 32'h0);
        check("R3 reset flags", {30'd0, up_full_o, dn_full_o}, 32'h0);
        scan(1'b1, 1'b0, 5'h08, 32'h0, cap);
        check("R3 first capture", cap[31:0], 32'h0);
        check("R1 capture upper zero", {26'd0, cap[37:32]}, 32'h0);

        // Vector table: write, read, compare
        for (int v = 0; v < NV; v++) begin
            wr_reg(VEC[v][68:64], VEC[v][63:32]);
            rd_reg(VEC[v][68:64], rd);
            check($sformatf("R4 vec %0d addr %02h", v, VEC[v][68:64]), rd, VEC[v][31:0]);
        end

        // Watch slot placement on the output bus
        check("R5 u0 s0", watch_o[0*32 +: 32], 32'h1111_1111);
        check("R5 u0 s3", watch_o[3*32 +: 32], 32'h4444_4444);
        check("R5 u0 s5", watch_o[5*32 +: 32], 32'h6666_6666);
        check("R5 u1 s0", watch_o[6*32 +: 32], 32'h7777_7777);
        check("R5 u1 s5", watch_o[11*32 +: 32], 32'hCCCC_CCCC);
        check("R2 vcatch out", {24'd0, vcatch_o}, 32'h0000_00FF);

        // Pipelined reads: each capture returns the previous scan's address
        scan(1'b1, 1'b0, 5'h08, 32'h0, cap);
        scan(1'b1, 1'b0, 5'h10, 32'h0, cap);
        check("R3 pipeline first", cap[31:0], 32'h1111_1111);
        scan(1'b1, 1'b0, 5'h04, 32'h0, cap);
        check("R3 pipeline second", cap[31:0], 32'h7777_7777);
        wr_reg(5'h03, 32'h0);
        scan(1'b1, 1'b0, 5'h04, 32'h0, cap);
        check("R3 capture after write", cap[31:0], 32'h0);

        // Control read-modify-write of bit 4
        wr_reg(5'h00, 32'h0000_002B);
        rd_reg(5'h00, rd);
        check("R8 ctrl read", rd, 32'h0000_002B);
        wr_reg(5'h00, rd | 32'h10);
        check("R8 monitor bit set", {26'd0, ctrl_o}, 32'h0000_003B);
        rd_reg(5'h00, rd);
        wr_reg(5'h00, rd & ~32'h10);
        check("R8 monitor bit clear", {26'd0, ctrl_o}, 32'h0000_002B);

        // Deselected scan attempts a control write
        scan(1'b0, 1'b1, 5'h00, 32'h0, cap);
        check("R9 deselected write ignored", {26'd0, ctrl_o}, 32'h0000_002B);

        // Up mailbox
        push_up(32'hCAFE_F00D);
        check("R11 up full after push", {31'd0, up_full_o}, 32'h1);
        rd_reg(5'h04, rd);
        check("R12 comctl up full", rd, 32'h2000_0002);
        rd_reg(5'h04, rd);
        check("R7 comctl read keeps flag", {31'd0, up_full_o}, 32'h1);
        rd_reg(5'h05, rd);
        check("R11 up word read", rd, 32'hCAFE_F00D);
        check("R6 up consumed", {31'd0, up_full_o}, 32'h0);
        push_up(32'h0BAD_F00D);
        scan(1'b1, 1'b0, 5'h05, 32'h0, cap);
        push_up(32'h5555_AAAA);
        scan(1'b1, 1'b0, 5'h05, 32'h0, cap);
        check("R6 repeated read data", cap[31:0], 32'h0BAD_F00D);
        check("R6 repeated read consumed", {31'd0, up_full_o}, 32'h0);

        // Down mailbox
        wr_reg(5'h05, 32'h1234_5678);
        check("R10 dn full", {31'd0, dn_full_o}, 32'h1);
        check("R10 dn word", dn_word_o, 32'h1234_5678);
        rd_reg(5'h04, rd);
        check("R12 comctl dn full", rd, 32'h2000_0001);
        dn_pop_i = 1'b1;
        @(posedge clk); @(negedge clk);
        dn_pop_i = 1'b0;
        check("R10 dn popped", {31'd0, dn_full_o}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule